// File: doc/BRIEF.md
# Shift-Down Result FIFO

This block buffers conversion results between a conversion engine and a bus reader that share one clock. It holds up to eight 13-bit words. Each word is a 12-bit result plus an out-of-range flag. Storage is a physical array in which the oldest word always sits at location 0. A new word is placed just above the highest occupied location. When a word is popped, every remaining word moves down one place. One register holds the fill level, and that level also tells the block where the next word goes.

The write side is a one-cycle strobe from the conversion engine. The read side is a one-cycle pop strobe. The read outputs always show location 0, so the word to be popped is visible in the cycle the strobe is given. The block also reports a fill count, empty and full flags, and a sticky overflow flag for words dropped while the block is full.

A small controller tracks the fill level with three states:
- ST_EMPTY: nothing is stored.
- ST_PART: between one and seven words are stored.
- ST_FULL: eight words are stored.

Its transitions are:
- EMPTY→PART on any accepted write.
- PART→FULL on a lone write at seven words.
- PART→EMPTY on a lone pop at one word.
- FULL→PART on a lone pop.

Every other combination stays in the current state. A full state with a lone write is where the overflow flag is set.

Top module: `shdn_result_fifo`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, overflow is 0, and the read outputs (data and flag) are all zero.
- R2: A write strobe with no pop while fewer than 8 words are stored raises count by one at the next clock.
- R3: The read outputs always show the oldest stored word, so words leave in the order they were written.
- R4: A pop with no write while the block is not empty lowers count by one, and the next-oldest word appears on the read outputs after that clock.
- R5: A pop and a write in the same cycle with 1 to 7 words stored leave count unchanged, and the new word becomes the youngest entry.
- R6: A pop while empty changes nothing: count stays 0, and the read outputs keep the last word that occupied location 0.
- R7: A write with no pop while 8 words are stored is dropped, count stays 8, and overflow goes to 1 and stays 1 until reset.
- R8: empty is 1 exactly when count is 0, and full is 1 exactly when count is 8.
- R9: A pop and a write in the same cycle while full are both taken: count stays 8 and overflow does not change.
- R10: A pop and a write in the same cycle while empty take only the write: count becomes 1, and the new word is shown on the read outputs.
- R11: The out-of-range flag travels with its 12-bit result through every shift. rd_oor always belongs to the same word as rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for writes, pops and shifting |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe from the conversion engine |
| wr_data | input | 12 | Result to store |
| wr_oor | input | 1 | Out-of-range flag for the result |
| rd_en | input | 1 | One-cycle pop strobe |
| rd_data | output | 12 | Result at location 0 |
| rd_oor | output | 1 | Out-of-range flag at location 0 |
| count | output | 4 | Number of stored words, 0 to 8 |
| empty | output | 1 | No words stored |
| full | output | 1 | Eight words stored |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
A wrong fill count steers the next write into the wrong location. That shows up as a hole or an overwritten word on the read outputs, at the latest when the block is drained to that depth. A count that drifts from the controller state shows as empty or full disagreeing with count in the very next cycle. A shift that moves data without its flag, or that misses an entry, shows on rd_data or rd_oor in the cycle after the pop that exposes the entry.

// File: rtl/shdn_fifo_pkg.sv
package shdn_fifo_pkg;

    localparam int RES_W = 12;

    typedef struct packed {
        logic             oor;
        logic [RES_W-1:0] data;
    } res_word_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_t;

endpackage

// File: rtl/shdn_fifo_ctrl.sv
module shdn_fifo_ctrl
    import shdn_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full,
    output logic             overflow,
    output logic [DEPTH-1:0] wr_hit,
    output logic [DEPTH-1:0] shift_mask
);

    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    fill_state_t   state, state_nxt;
    logic          rd_acc, wr_acc;
    logic [CW-1:0] count_nxt;
    logic [CW-1:0] wr_pos;

    // A pop is taken whenever something is stored. A write is taken unless
    // the block is full, except that a same-cycle pop frees a slot.
    assign rd_acc = rd_en && (state != ST_EMPTY);
    assign wr_acc = wr_en && ((state != ST_FULL) || rd_acc);

    always_comb begin
        unique case ({wr_acc, rd_acc})
            2'b10:   count_nxt = count + CNT_ONE;
            2'b01:   count_nxt = count - CNT_ONE;
            default: count_nxt = count;
        endcase
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (wr_acc) state_nxt = ST_PART;
            end
            ST_PART: begin
                if (wr_acc && !rd_acc && count == CNT_LAST)
                    state_nxt = ST_FULL;
                else if (rd_acc && !wr_acc && count == CNT_ONE)
                    state_nxt = ST_EMPTY;
            end
            ST_FULL: begin
                if (rd_acc && !wr_acc) state_nxt = ST_PART;
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_EMPTY;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
            if (wr_en && !wr_acc) overflow <= 1'b1;
        end
    end

    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state)
            ST_EMPTY: empty = 1'b1;
            ST_PART:  ;
            ST_FULL:  full = 1'b1;
            default:  empty = 1'b1;
        endcase
    end

    // With a same-cycle pop the stack moves down first, so the new word
    // lands one place below the current fill level.
    assign wr_pos = rd_acc ? (count - CNT_ONE) : count;

    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        assign wr_hit[i]     = wr_acc && (wr_pos == CW'(i));
        assign shift_mask[i] = rd_acc && (count > CW'(i + 1));
    end

    assert_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (count == '0)) && (full == (count == CNT_FULL)));

    assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !full) |=> (count == $past(count) + CNT_ONE));

    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !empty) |=> (count == $past(count) - CNT_ONE));

    assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && !empty) |=> $stable(count));

    assert_no_overflow_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && overflow));

    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_full_rw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_en) |=> (full && $stable(overflow)));

    assert_hit_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));

endmodule

// File: rtl/shdn_fifo_array.sv
module shdn_fifo_array
    import shdn_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] wr_hit,
    input  logic [DEPTH-1:0] shift_mask,
    input  res_word_t        wr_word,
    output res_word_t        bottom
);

    res_word_t loc [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_loc
        res_word_t above;
        if (i == DEPTH - 1) begin : g_top
            assign above = '0;
        end else begin : g_mid
            assign above = loc[i + 1];
        end

        // The write wins over the shift. The controller never asks for
        // both on one location.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                loc[i] <= '0;
            end else if (wr_hit[i]) begin
                loc[i] <= wr_word;
            end else if (shift_mask[i]) begin
                loc[i] <= above;
            end
        end

        assert_no_clash_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_hit[i] && shift_mask[i]));
    end

    assign bottom = loc[0];

endmodule

// File: rtl/shdn_result_fifo.sv
module shdn_result_fifo
    import shdn_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RES_W-1:0] wr_data,
    input  logic             wr_oor,
    input  logic             rd_en,
    output logic [RES_W-1:0] rd_data,
    output logic             rd_oor,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full,
    output logic             overflow
);

    logic [DEPTH-1:0] wr_hit;
    logic [DEPTH-1:0] shift_mask;
    res_word_t        wr_word;
    res_word_t        bottom;

    assign wr_word = '{oor: wr_oor, data: wr_data};

    shdn_fifo_ctrl #(.DEPTH(DEPTH), .CW(CW)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .count      (count),
        .empty      (empty),
        .full       (full),
        .overflow   (overflow),
        .wr_hit     (wr_hit),
        .shift_mask (shift_mask)
    );

    shdn_fifo_array #(.DEPTH(DEPTH)) i_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .shift_mask (shift_mask),
        .wr_word    (wr_word),
        .bottom     (bottom)
    );

    assign rd_data = bottom.data;
    assign rd_oor  = bottom.oor;

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> ($stable({rd_oor, rd_data}) && empty));

    assert_first_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr_en) |=> ({rd_oor, rd_data} == $past({wr_oor, wr_data}) &&
                              count == CW'(1)));

    assert_bottom_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !empty) |=> $stable({rd_oor, rd_data}));

endmodule

// File: tb/test_shdn_result_fifo.sv
module test_shdn_result_fifo;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic        wr_oor = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_data;
    logic        rd_oor;
    logic [3:0]  count;
    logic        empty, full, overflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [12:0] mq [DEPTH];
    int          mcnt;
    logic [12:0] mlast;
    bit          movf;

    always #2 clk = ~clk;

    shdn_result_fifo i_shdn_result_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_oor(wr_oor), .rd_en(rd_en), .rd_data(rd_data), .rd_oor(rd_oor),
        .count(count), .empty(empty), .full(full), .overflow(overflow)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_word();
        return (mcnt > 0) ? mq[0] : mlast;
    endfunction

    function automatic string tag_of(bit w, bit r);
        if (mcnt == 0 && w && r)     return "R10";
        if (mcnt == DEPTH && w && r) return "R9";
        if (mcnt == DEPTH && w)      return "R7";
        if (mcnt == 0 && r)          return "R6";
        if (w && r)                  return "R5";
        if (w)                       return "R2";
        if (r)                       return "R4";
        return "R3";
    endfunction

    function automatic void model_step(bit w, bit r, logic [12:0] nw);
        bit pop = r && (mcnt > 0);
        bit put = w && ((mcnt < DEPTH) || pop);
        if (w && !put) movf = 1;
        if (pop) begin
            mlast = mq[0];
            for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i + 1];
            mcnt--;
        end
        if (put) begin
            mq[mcnt] = nw;
            mcnt++;
        end
    endfunction

    task automatic compare(string tag);
        logic [12:0] ew = exp_word();
        chk(tag, int'(count), mcnt);
        chk({tag, "/R3"}, int'(rd_data), int'(ew[11:0]));
        chk({tag, "/R11"}, int'(rd_oor), int'(ew[12]));
        chk("R8 empty", int'(empty), int'(mcnt == 0));
        chk("R8 full", int'(full), int'(mcnt == DEPTH));
        chk("R7 overflow", int'(overflow), int'(movf));
    endtask

    // Called at a falling edge: drive, let one rising edge pass, then check.
    task automatic step(bit w, bit r, logic [12:0] nw);
        string tag = tag_of(w, r);
        wr_en = w; rd_en = r; wr_oor = nw[12]; wr_data = nw[11:0];
        @(posedge clk);
        model_step(w, r, nw);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        compare(tag);
    endtask

    initial begin
        mcnt = 0; mlast = '0; movf = 0;
        for (int i = 0; i < DEPTH; i++) mq[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1");

        step(0, 1, 13'h0);              // R6 pop on empty after reset
        for (int i = 0; i < DEPTH; i++)  // R2 fill, alternating flag for R11
            step(1, 0, {1'(i % 2), 12'(12'h100 + i)});
        step(1, 0, 13'h1ABC);           // R7 dropped
        step(0, 0, 13'h0);              // R7 sticky
        step(1, 1, 13'h0555);           // R9
        for (int i = 0; i < DEPTH; i++) step(0, 1, 13'h0); // R4 drain, R3 order
        step(0, 1, 13'h0);              // R6 holds last word
        step(1, 1, 13'h1777);           // R10
        step(1, 1, 13'h0888);           // R5 single-word exchange

        for (int n = 0; n < 3000; n++) begin
            int k = $urandom_range(0, 9);
            bit w = (k < 5) || (k == 9);
            bit r = (k >= 4);
            step(w, r, 13'($urandom));
            if (n == 1500) begin
                rst_n = 0;
                @(negedge clk);
                rst_n = 1;
                mcnt = 0; mlast = '0; movf = 0;
                for (int i = 0; i < DEPTH; i++) mq[i] = '0;
                @(negedge clk);
                compare("R1");
            end
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule